// File: doc/BRIEF.md
# Key-Protected Reset Controller

This block sequences software-commanded resets and watches an active-low external reset line for presses that originate outside the chip. Software reaches it through three word registers on a single-cycle synchronous bus: a mode register, a write-only command register and a read-only status register. Every write to the mode or command register must carry a fixed key byte in the top byte of the write data. A write with any other key changes nothing.

A command can pulse the processor reset output for a fixed count of clock cycles, or drive the external line low for a power-of-two count chosen in the mode register, or do both at once. While any commanded pulse is running the controller reports busy and refuses further commands. The external line is synchronised before use. A falling edge on it that the controller did not cause itself sets a sticky status flag. That flag can raise an interrupt, and reading the status register clears it. The whole block runs on the slow clock.

Top module: `rstctl_top`

## Requirements
- R1: After reset the mode register reads 0, the status register reads 0x0001_0000 (flag 0, busy 0, line level 1), both reset outputs are high and `irq` is low.
- R2: A write to the mode register (address 0) or the command register (address 1) takes effect only when `bus_wdata[31:24]` equals 0xA5. With any other key value the mode readback and both reset outputs stay unchanged.
- R3: The mode register keeps user-reset enable at bit 0, interrupt enable at bit 4 and length N at bits [11:8]. A read of address 0 returns these bits and zero everywhere else.
- R4: A keyed command with bit 3 set drives `ext_rst_n_out` low for exactly 2^(N+1) clock cycles. The low level starts on the clock edge that accepts the write.
- R5: A keyed command with bit 0 set drives `proc_rst_n` low for exactly 3 clock cycles, starting on the accepting edge. Bits 0 and 3 may be set together.
- R6: Status bit 17 (busy) reads 1 exactly while at least one reset output is low. It falls only when every commanded pulse has ended.
- R7: A command written while busy is 1 is ignored. The running pulses keep their lengths and no new pulse starts.
- R8: Status bit 0 is set on a falling edge of the synchronised line only while mode bit 0 is 1. With mode bit 0 at 0, a press leaves the flag at 0.
- R9: A low pulse driven by the controller itself does not set status bit 0.
- R10: Status bit 0 stays set across further presses and idle cycles until a read of the status register (address 2). That read returns 1, and the next read returns 0.
- R11: `irq` equals status bit 0 AND mode bit 4.
- R12: Status bit 16 reports the line level after a two-stage synchroniser. A low level reaches it on the second clock edge after the line falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock for the whole block |
| rst_n | input | 1 | Asynchronous active-low block reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 2 | Word address: 0 mode, 1 command, 2 status |
| bus_wdata | input | 32 | Write data, key in [31:24] |
| bus_rdata | output | 32 | Read data for the addressed register |
| ext_rst_n_in | input | 1 | Observed level of the external reset line |
| ext_rst_n_out | output | 1 | Drive of the external reset line, low active |
| proc_rst_n | output | 1 | Processor reset, low active |
| irq | output | 1 | User-reset interrupt, level |

## Verification
The checker assumes two things about the line input. It falls only when an outside press occurs or when the block drives it. An outside press never overlaps a commanded pulse or the few cycles that follow it. The bench builds the line as the AND of the block's own drive and a modelled push button. It presses the button only while the controller is idle, and it keeps the button released through every commanded pulse. Bus accesses are single cycles qualified by `bus_sel`, and the key byte counts only during writes. The bench drives the bus on falling clock edges, so every access is stable at the sampling edge.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;

    localparam int unsigned LEN_W     = 4;
    localparam int unsigned DATA_W    = 32;
    localparam int unsigned ADDR_W    = 2;
    localparam int unsigned KEY_W     = 8;
    localparam int unsigned KEY_LSB   = DATA_W - KEY_W;
    localparam logic [KEY_W-1:0] WR_KEY = 8'hA5;

    localparam logic [ADDR_W-1:0] A_MODE = 2'd0;
    localparam logic [ADDR_W-1:0] A_CTRL = 2'd1;
    localparam logic [ADDR_W-1:0] A_STAT = 2'd2;

    // mode register fields
    localparam int unsigned M_UE      = 0;
    localparam int unsigned M_IE      = 4;
    localparam int unsigned M_LEN_LSB = 8;

    // command register bits
    localparam int unsigned C_PROC = 0;
    localparam int unsigned C_EXT  = 3;

    // status register bits
    localparam int unsigned S_FLAG  = 0;
    localparam int unsigned S_LEVEL = 16;
    localparam int unsigned S_BUSY  = 17;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic             ie;
        logic             ue;
    } mode_t;

endpackage

// File: rtl/rstctl_pinmon.sv
// Synchroniser and falling-edge detector for the external reset line.
module rstctl_pinmon #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic level,
    output logic fall
);

    logic [STAGES-1:0] sync_d, sync_q;
    logic              prev_d, prev_q;

    generate
        if (STAGES > 1) begin : g_chain
            always_comb sync_d = {sync_q[STAGES-2:0], pin_n};
        end else begin : g_single
            always_comb sync_d = pin_n;
        end
    endgenerate

    always_comb begin
        prev_d = sync_q[STAGES-1];
        level  = sync_q[STAGES-1];
        fall   = prev_q & ~sync_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= sync_d;
            prev_q <= prev_d;
        end
    end

endmodule

// File: rtl/rstctl_pulse.sv
// Loadable down-counter: active while the count is non-zero.
module rstctl_pulse #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] load,
    output logic         active
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = load;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - W'(1);
        end
        active = (cnt_q != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/rstctl_top.sv
module rstctl_top
    import rstctl_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned PROC_CYC    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ext_rst_n_in,
    output logic              ext_rst_n_out,
    output logic              proc_rst_n,
    output logic              irq
);

    localparam int unsigned GUARD_CYC = SYNC_STAGES + 1;
    localparam int unsigned GUARD_W   = $clog2(GUARD_CYC + 1);
    localparam int unsigned EXT_W     = (1 << LEN_W) + 1;
    localparam int unsigned PROC_W    = $clog2(PROC_CYC + 1);

    typedef struct packed {
        mode_t              mode;
        logic               flag;
        logic [GUARD_W-1:0] guard;
    } ctl_t;

    ctl_t st_d, st_q;

    logic              pin_level, pin_fall;
    logic              ext_active, proc_active, busy;
    logic              key_ok, mode_wr, cmd_wr, status_rd, user_hit;
    logic              ext_start, proc_start;
    logic [EXT_W-1:0]  ext_load;
    logic [PROC_W-1:0] proc_load;
    logic [LEN_W:0]    shamt;
    logic              user_flag;
    logic [LEN_W+1:0]  mode_bits;
    logic              unused_wbits;

    rstctl_pinmon #(.STAGES(SYNC_STAGES)) u_pin (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_n (ext_rst_n_in),
        .level (pin_level),
        .fall  (pin_fall)
    );

    rstctl_pulse #(.W(EXT_W)) u_ext (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (ext_start),
        .load   (ext_load),
        .active (ext_active)
    );

    rstctl_pulse #(.W(PROC_W)) u_proc (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (proc_start),
        .load   (proc_load),
        .active (proc_active)
    );

    // bus decode and command acceptance
    always_comb begin
        key_ok     = (bus_wdata[KEY_LSB +: KEY_W] == WR_KEY);
        mode_wr    = bus_sel & bus_wr & (bus_addr == A_MODE) & key_ok;
        busy       = ext_active | proc_active;
        cmd_wr     = bus_sel & bus_wr & (bus_addr == A_CTRL) & key_ok & ~busy;
        status_rd  = bus_sel & ~bus_wr & (bus_addr == A_STAT);
        ext_start  = cmd_wr & bus_wdata[C_EXT];
        proc_start = cmd_wr & bus_wdata[C_PROC];
        shamt      = {1'b0, st_q.mode.len} + {{LEN_W{1'b0}}, 1'b1};
        ext_load   = EXT_W'(1) << shamt;
        proc_load  = PROC_W'(PROC_CYC);
        unused_wbits = ^{bus_wdata[KEY_LSB-1:M_LEN_LSB+LEN_W],
                         bus_wdata[M_LEN_LSB-1:M_IE+1],
                         bus_wdata[M_IE-1:C_EXT+1],
                         bus_wdata[C_EXT-1:C_PROC+1]};
    end

    // next state of mode, flag and self-drive guard
    always_comb begin
        st_d = st_q;
        if (mode_wr) begin
            st_d.mode.ue  = bus_wdata[M_UE];
            st_d.mode.ie  = bus_wdata[M_IE];
            st_d.mode.len = bus_wdata[M_LEN_LSB +: LEN_W];
        end
        if (ext_active) begin
            st_d.guard = GUARD_W'(GUARD_CYC);
        end else if (st_q.guard != '0) begin
            st_d.guard = st_q.guard - GUARD_W'(1);
        end
        user_hit = pin_fall & st_q.mode.ue & ~ext_active & (st_q.guard == '0);
        if (status_rd) st_d.flag = 1'b0;
        if (user_hit)  st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // read mux and outputs
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_MODE: begin
                bus_rdata[M_UE]                = st_q.mode.ue;
                bus_rdata[M_IE]                = st_q.mode.ie;
                bus_rdata[M_LEN_LSB +: LEN_W]  = st_q.mode.len;
            end
            A_STAT: begin
                bus_rdata[S_FLAG]  = st_q.flag;
                bus_rdata[S_LEVEL] = pin_level;
                bus_rdata[S_BUSY]  = busy;
            end
            default: bus_rdata = '0;
        endcase
        ext_rst_n_out = ~ext_active;
        proc_rst_n    = ~proc_active;
        irq           = st_q.flag & st_q.mode.ie;
        user_flag     = st_q.flag;
        mode_bits     = st_q.mode;
    end

endmodule

// File: rtl/rstctl_chk.sv
module rstctl_chk
    import rstctl_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [KEY_W-1:0]  wkey,
    input logic              proc_rst_n,
    input logic              ext_rst_n_out,
    input logic              busy,
    input logic              flag,
    input logic              status_rd,
    input logic [LEN_W+1:0]  mode_q
);

    // R2: a mode write with a wrong key leaves the mode unchanged
    assert_badkey_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == A_MODE && wkey != WR_KEY) |=> $stable(mode_q));

    // R5: processor reset low for three cycles
    assert_proc_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(proc_rst_n) |=> !proc_rst_n ##1 !proc_rst_n ##1 proc_rst_n);

    // R6: busy falls only when both outputs are released
    assert_busy_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (ext_rst_n_out && proc_rst_n));

    // R7: no pulse starts while busy was set
    assert_no_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ext_rst_n_out) || $fell(proc_rst_n)) |-> !$past(busy));

    // R8: flag rises only with user-reset enable set
    assert_flag_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(mode_q[0]));

    // R10: flag is sticky until a status read
    assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !status_rd) |=> flag);

endmodule

bind rstctl_top rstctl_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_sel       (bus_sel),
    .bus_wr        (bus_wr),
    .bus_addr      (bus_addr),
    .wkey          (bus_wdata[31:24]),
    .proc_rst_n    (proc_rst_n),
    .ext_rst_n_out (ext_rst_n_out),
    .busy          (busy),
    .flag          (user_flag),
    .status_rd     (status_rd),
    .mode_q        (mode_bits)
);

// File: tb/sim_rstctl_top.sv
module sim_rstctl_top;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYC   = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        ext_rst_n_in;
    logic        ext_rst_n_out;
    logic        proc_rst_n;
    logic        irq;
    logic        btn_n = 1'b1;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    assign ext_rst_n_in = ext_rst_n_out & btn_n;

    rstctl_top u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_rst_n_in(ext_rst_n_in), .ext_rst_n_out(ext_rst_n_out),
        .proc_rst_n(proc_rst_n), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mode_word(input logic [7:0] key, input logic ue,
                                              input logic ie, input logic [3:0] len);
        return {key, 12'd0, len, 3'd0, ie, 3'd0, ue};
    endfunction

    function automatic logic [31:0] ctl_word(input logic [7:0] key, input logic ext,
                                             input logic prc);
        return {key, 20'd0, ext, 2'd0, prc};
    endfunction

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = 32'd0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        @(posedge clk);
        #1;
        bus_sel = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic press(input int n);
        @(negedge clk);
        btn_n = 1'b0;
        repeat (n) @(negedge clk);
        btn_n = 1'b1;
    endtask

    // issue a command, then poll status each cycle; optionally a second command at cycle late_at
    task automatic run_cmd(input logic [31:0] ctl, input int late_at, input logic [31:0] late_ctl,
                           output int ext_lo, output int proc_lo, output int busy_bad);
        logic exp_busy;
        ext_lo = 0; proc_lo = 0; busy_bad = 0;
        wr(2'd1, ctl);
        for (int cyc = 0; cyc < 70000; cyc++) begin
            @(negedge clk);
            if (cyc == late_at) begin
                bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = late_ctl;
            end else begin
                bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 2'd2; bus_wdata = 32'd0;
            end
            #1;
            if (ext_rst_n_out && proc_rst_n && cyc > late_at) break;
            if (!ext_rst_n_out) ext_lo++;
            if (!proc_rst_n) proc_lo++;
            if (cyc != late_at) begin
                exp_busy = !ext_rst_n_out || !proc_rst_n;
                if (bus_rdata[17] !== exp_busy) busy_bad++;
            end
        end
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = 32'd0;
    endtask

    initial begin
        repeat (WDOG_CYC) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] exp_mode;
        int e, p, b;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        idle(1);
        chk("R1 proc_rst_n", {31'd0, proc_rst_n}, 32'd1);
        chk("R1 ext_rst_n_out", {31'd0, ext_rst_n_out}, 32'd1);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        rd(2'd0, d); chk("R1 mode", d, 32'd0);
        rd(2'd2, d); chk("R1 status", d, 32'h0001_0000);

        // R3 readback masks unused bits
        wr(2'd0, 32'hA5FF_FFFF);
        rd(2'd0, d); chk("R3 mode readback", d, 32'h0000_0F11);
        rd(2'd1, d); chk("R3 command reads zero", d, 32'd0);

        // R2 exhaustive key sweep on the mode register
        wr(2'd0, mode_word(8'hA5, 1'b0, 1'b0, 4'd0));
        exp_mode = 32'd0;
        for (int k = 0; k < 256; k++) begin
            wr(2'd0, mode_word(k[7:0], 1'b1, 1'b1, k[3:0]));
            if (k[7:0] == 8'hA5) exp_mode = mode_word(8'h00, 1'b1, 1'b1, k[3:0]);
            rd(2'd0, d); chk("R2 mode key sweep", d, exp_mode);
        end
        wr(2'd0, mode_word(8'hA5, 1'b0, 1'b0, 4'd0));

        // R2 command with wrong keys
        for (int k = 0; k < 4; k++) begin
            logic [7:0] bad;
            bad = (k == 0) ? 8'h00 : (k == 1) ? 8'hA4 : (k == 2) ? 8'hA6 : 8'h5A;
            run_cmd(ctl_word(bad, 1'b1, 1'b1), -1, 32'd0, e, p, b);
            chk("R2 bad key ext", e, 0);
            chk("R2 bad key proc", p, 0);
        end

        // R4 ext pulse length sweep, R6 busy tracking
        for (int n = 0; n < 12; n++) begin
            wr(2'd0, mode_word(8'hA5, 1'b0, 1'b0, n[3:0]));
            run_cmd(ctl_word(8'hA5, 1'b1, 1'b0), -1, 32'd0, e, p, b);
            chk("R4 ext length", e, 32'd1 << (n + 1));
            chk("R4 no proc", p, 0);
            chk("R6 busy during ext", b, 0);
            idle(2);
        end

        // R5 proc alone
        run_cmd(ctl_word(8'hA5, 1'b0, 1'b1), -1, 32'd0, e, p, b);
        chk("R5 proc length", p, 3);
        chk("R5 no ext", e, 0);
        chk("R6 busy during proc", b, 0);

        // R5/R6 both together, N=0 (ext shorter) and N=3 (ext longer)
        wr(2'd0, mode_word(8'hA5, 1'b0, 1'b0, 4'd0));
        run_cmd(ctl_word(8'hA5, 1'b1, 1'b1), -1, 32'd0, e, p, b);
        chk("R5 both proc", p, 3);
        chk("R4 both ext", e, 2);
        chk("R6 busy both short", b, 0);
        wr(2'd0, mode_word(8'hA5, 1'b0, 1'b0, 4'd3));
        run_cmd(ctl_word(8'hA5, 1'b1, 1'b1), -1, 32'd0, e, p, b);
        chk("R5 both proc long", p, 3);
        chk("R4 both ext long", e, 16);
        chk("R6 busy both long", b, 0);
        rd(2'd2, d); chk("R6 busy clear after", {31'd0, d[17]}, 32'd0);

        // R7 commands while busy
        run_cmd(ctl_word(8'hA5, 1'b1, 1'b0), 4, ctl_word(8'hA5, 1'b1, 1'b1), e, p, b);
        chk("R7 ext kept", e, 16);
        chk("R7 proc not started", p, 0);
        run_cmd(ctl_word(8'hA5, 1'b0, 1'b1), 1, ctl_word(8'hA5, 1'b1, 1'b1), e, p, b);
        chk("R7 proc kept", p, 3);
        chk("R7 ext not started", e, 0);
        idle(4);

        // R12 synchronised level latency
        wr(2'd0, mode_word(8'hA5, 1'b0, 1'b0, 4'd0));
        @(negedge clk); btn_n = 1'b0;
        rd(2'd2, d); chk("R12 level after one edge", {31'd0, d[16]}, 32'd1);
        rd(2'd2, d); chk("R12 level after two edges", {31'd0, d[16]}, 32'd0);
        @(negedge clk); btn_n = 1'b1;
        idle(4);
        rd(2'd2, d); chk("R12 level back high", {31'd0, d[16]}, 32'd1);
        chk("R8 disabled press no flag", {31'd0, d[0]}, 32'd0);

        // R8/R10/R11 enabled with interrupt
        wr(2'd0, mode_word(8'hA5, 1'b1, 1'b1, 4'd2));
        rd(2'd2, d);
        press(4); idle(5);
        chk("R11 irq raised", {31'd0, irq}, 32'd1);
        rd(2'd2, d); chk("R8 flag set", {31'd0, d[0]}, 32'd1);
        rd(2'd2, d); chk("R10 flag cleared by read", {31'd0, d[0]}, 32'd0);
        chk("R11 irq cleared", {31'd0, irq}, 32'd0);

        // R10 sticky over two presses and idle time
        press(3); idle(4); press(3); idle(12);
        chk("R10 flag still set via irq", {31'd0, irq}, 32'd1);
        rd(2'd2, d); chk("R10 sticky read", {31'd0, d[0]}, 32'd1);
        rd(2'd2, d); chk("R10 second read", {31'd0, d[0]}, 32'd0);

        // R8 disabled
        wr(2'd0, mode_word(8'hA5, 1'b0, 1'b1, 4'd2));
        press(4); idle(5);
        chk("R11 irq off when disabled", {31'd0, irq}, 32'd0);
        rd(2'd2, d); chk("R8 no flag when disabled", {31'd0, d[0]}, 32'd0);

        // R11 interrupt enable off
        wr(2'd0, mode_word(8'hA5, 1'b1, 1'b0, 4'd2));
        press(4); idle(5);
        chk("R11 irq masked", {31'd0, irq}, 32'd0);
        rd(2'd2, d); chk("R8 flag with irq masked", {31'd0, d[0]}, 32'd1);

        // R9 self-driven pulses, shortest and longer
        for (int n = 0; n < 3; n++) begin
            wr(2'd0, mode_word(8'hA5, 1'b1, 1'b1, n[3:0]));
            rd(2'd2, d);
            wr(2'd1, ctl_word(8'hA5, 1'b1, 1'b0));
            idle((2 << n) + 8);
            chk("R9 no irq from own pulse", {31'd0, irq}, 32'd0);
            rd(2'd2, d); chk("R9 no flag from own pulse", {31'd0, d[0]}, 32'd0);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule